// File: doc/BRIEF.md
# Octant-Folded Quadrature Lookup Oscillator

This block is a numerically controlled oscillator that produces a signed sine sample and a signed cosine sample of the same angle on every enabled clock. A phase accumulator of `ACC_W` bits adds a programmable increment, plus a signed modulation word, on each enabled clock. The output frequency is therefore `f_clk * (phase_inc + fm_word) / 2^ACC_W`. An increment of one gives the lowest frequency, `f_clk / 2^ACC_W`.

The accumulated phase can optionally be offset by a small pseudo-random dither, to break up periodic truncation spurs, before it is cut down to `PH_W` bits. The three most significant of those bits name one of eight 45-degree sectors. The remaining bits address a table that holds sine and cosine for the first sector only. All other sectors are rebuilt from that table by mirroring the address, exchanging the two values and negating them. The table is computed when the design is elaborated, so no memory image is needed.

Top module: `nco_octant_osc`

## Requirements
- R1: While reset is asserted and before the first enabled clock, `out_valid`, `sin_o` and `cos_o` are all zero.
- R2: With dither off, the k-th valid sample (k = 0, 1, ...) after reset uses the phase `P = k * (phase_inc + fm_word) mod 2^ACC_W`. Let `idx` be the top `PH_W` bits of P and `A = 2^(OUT_W-1) - 1`. Then `sin_o = round(A * sin(2*pi*(idx+0.5)/2^PH_W))` and `cos_o` is the same with cosine, where round means round half away from zero.
- R3: Bits [PH_W-1:PH_W-3] of the truncated phase select the sector. All eight sectors, 0 through 7, give the R2 values, even though only sector 0 is stored.
- R4: `fm_word` is treated as a two's-complement value and is added to `phase_inc` on each enabled clock. A negative word lowers the phase step.
- R5: While `clk_en` is low, `sin_o`, `cos_o` and the phase hold, and `phase_inc` is ignored. `out_valid` is low from the first clock edge with `clk_en` low.
- R6: `out_valid` first rises at the second enabled clock edge after reset, carrying sample k = 0 (phase 0). It then stays high on every clock edge while `clk_en` stays high.
- R7: With `dith_en` high, a signed `DITH_W`-bit pseudo-random offset is added to the accumulator before truncation. Each output then equals the R2 value for `idx-1`, `idx` or `idx+1` (mod 2^PH_W), and the offset does move the index for some samples. With `dith_en` low, the result matches R2 exactly.
- R8: Neither output ever takes the most negative code `-2^(OUT_W-1)`.
- R9: For every valid sample, `sin_o^2 + cos_o^2` lies within `2A+1` of `A^2`.
- R10: With `phase_inc = 1` and no modulation, the table index advances by one every `2^(ACC_W-PH_W)` samples, which is the lowest frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Advances the accumulator and the pipeline when high |
| phase_inc | input | ACC_W | Unsigned phase step per enabled clock |
| fm_word | input | ACC_W | Signed modulation added to the phase step |
| dith_en | input | 1 | Adds the pseudo-random phase offset when high |
| sin_o | output | OUT_W | Signed sine sample |
| cos_o | output | OUT_W | Signed cosine sample |
| out_valid | output | 1 | A new sample is present this cycle |

## Verification
The hardest case to reach from the ports is a dither offset that pulls the phase across a table-index boundary. With an arbitrary accumulator value, the low bits usually sit far from any boundary and the dither has no visible effect. The bench therefore resets the block and holds the increment at zero, so the phase stays at exactly zero. Every negative offset then wraps the index to the last entry of sector 7. The other paths are reached with chosen phase steps: a coarse step sweeps all eight sectors, a step of one crawls through a single table entry, and an increment with a negative modulation word reaches further indices.

// File: rtl/nco_octant_pkg.sv
package nco_octant_pkg;

    // Sector handling derived from the three top phase bits
    typedef struct packed {
        logic mirror;   // address runs backwards inside the sector
        logic swap;     // sine and cosine exchange roles
        logic neg_s;    // negate sine output
        logic neg_c;    // negate cosine output
    } fold_t;

    function automatic fold_t sector_fold(input logic [2:0] sec);
        fold_t f;
        f.mirror = sec[0];
        f.swap   = sec[0] ^ sec[1];
        f.neg_s  = sec[2];
        f.neg_c  = sec[1] ^ sec[2];
        return f;
    endfunction

    // First-sector table entry, sampled at the centre of each address step
    function automatic int sector_entry(input int addr, input int addr_bits,
                                        input int amp, input bit want_cos);
        real step;
        real ang;
        real v;
        step = 3.14159265358979323846 / (4.0 * real'(1 << addr_bits));
        ang  = (real'(addr) + 0.5) * step;
        v    = real'(amp) * (want_cos ? $cos(ang) : $sin(ang));
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] inc,
    input  logic [ACC_W-1:0] fm,
    output logic [ACC_W-1:0] acc_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.acc = st_q.acc + inc + fm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;
endmodule

// File: rtl/nco_dither_lfsr.sv
module nco_dither_lfsr #(
    parameter int DITH_W = 4,
    parameter int LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dith_en,
    output logic [DITH_W-1:0] dith_o
);
    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.lfsr = st_q.lfsr >> 1;
            if (st_q.lfsr[0]) begin
                st_d.lfsr = st_d.lfsr ^ TAPS;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lfsr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign dith_o = dith_en ? DITH_W'(st_q.lfsr) : '0;
endmodule

// File: rtl/nco_octant_rom.sv
module nco_octant_rom
    import nco_octant_pkg::*;
#(
    parameter int PH_W  = 10,
    parameter int OUT_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [PH_W-1:0]         ph,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o
);
    localparam int ADDR_W = PH_W - 3;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MAG_W  = OUT_W - 1;
    localparam int AMP    = (1 << MAG_W) - 1;

    logic [MAG_W-1:0] sin_tab [DEPTH];
    logic [MAG_W-1:0] cos_tab [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_tab
        localparam logic [MAG_W-1:0] SV = MAG_W'(sector_entry(i, ADDR_W, AMP, 1'b0));
        localparam logic [MAG_W-1:0] CV = MAG_W'(sector_entry(i, ADDR_W, AMP, 1'b1));
        assign sin_tab[i] = SV;
        assign cos_tab[i] = CV;
    end

    typedef struct packed {
        logic signed [OUT_W-1:0] s;
        logic signed [OUT_W-1:0] c;
    } rom_st_t;

    rom_st_t st_d, st_q;

    fold_t            fold;
    logic [ADDR_W-1:0] addr;
    logic [MAG_W-1:0] s_mag, c_mag, a_mag, b_mag;

    always_comb begin
        st_d  = st_q;
        fold  = sector_fold(ph[PH_W-1 -: 3]);
        addr  = fold.mirror ? ~ph[ADDR_W-1:0] : ph[ADDR_W-1:0];
        s_mag = sin_tab[addr];
        c_mag = cos_tab[addr];
        a_mag = fold.swap ? c_mag : s_mag;
        b_mag = fold.swap ? s_mag : c_mag;
        if (en) begin
            st_d.s = fold.neg_s ? -$signed({1'b0, a_mag}) : $signed({1'b0, a_mag});
            st_d.c = fold.neg_c ? -$signed({1'b0, b_mag}) : $signed({1'b0, b_mag});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sin_o = st_q.s;
    assign cos_o = st_q.c;
endmodule

// File: rtl/nco_octant_osc.sv
module nco_octant_osc #(
    parameter int ACC_W  = 16,
    parameter int PH_W   = 10,
    parameter int OUT_W  = 12,
    parameter int DITH_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic [ACC_W-1:0]        phase_inc,
    input  logic [ACC_W-1:0]        fm_word,
    input  logic                    dith_en,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o,
    output logic                    out_valid
);
    localparam int TRUNC = ACC_W - PH_W;

    logic [ACC_W-1:0]  acc;
    logic [DITH_W-1:0] dith;
    logic [ACC_W-1:0]  dith_ext;
    logic [ACC_W-1:0]  dsum;

    nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .inc   (phase_inc),
        .fm    (fm_word),
        .acc_o (acc)
    );

    nco_dither_lfsr #(.DITH_W(DITH_W)) u_dith (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (clk_en),
        .dith_en (dith_en),
        .dith_o  (dith)
    );

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            ph_v;
        logic            out_v;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        dith_ext = {{(ACC_W-DITH_W){dith[DITH_W-1]}}, dith};
        dsum     = acc + dith_ext;
        if (clk_en) begin
            st_d.ph    = PH_W'(dsum >> TRUNC);
            st_d.ph_v  = 1'b1;
            st_d.out_v = st_q.ph_v;
        end else begin
            st_d.out_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    nco_octant_rom #(.PH_W(PH_W), .OUT_W(OUT_W)) u_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .ph    (st_q.ph),
        .sin_o (sin_o),
        .cos_o (cos_o)
    );

    assign out_valid = st_q.out_v;
endmodule

// File: rtl/nco_octant_osc_chk.sv
module nco_octant_osc_chk #(
    parameter int OUT_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clk_en,
    input logic signed [OUT_W-1:0] sin_o,
    input logic signed [OUT_W-1:0] cos_o,
    input logic                    out_valid
);
    localparam int AMP  = (1 << (OUT_W-1)) - 1;
    localparam logic signed [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    int energy;
    int err;
    always_comb begin
        energy = int'(sin_o) * int'(sin_o) + int'(cos_o) * int'(cos_o);
        err    = energy - AMP * AMP;
    end

    assert_valid_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> !out_valid);

    assert_valid_sustained_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && clk_en) |=> out_valid);

    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(sin_o) && $stable(cos_o)));

    assert_no_min_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (sin_o != MIN_CODE && cos_o != MIN_CODE));

    assert_quad_energy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (err <= 2*AMP+1 && err >= -(2*AMP+1)));
endmodule

bind nco_octant_osc nco_octant_osc_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .sin_o     (sin_o),
    .cos_o     (cos_o),
    .out_valid (out_valid)
);

// File: tb/nco_octant_osc_tb.sv
`timescale 1ns/1ps
module nco_octant_osc_tb_top;
    localparam int ACC_W = 16;
    localparam int PH_W  = 10;
    localparam int OUT_W = 12;
    localparam int NIDX  = 1 << PH_W;
    localparam real AMPR = 2047.0;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    clk_en = 1'b0;
    logic [ACC_W-1:0]        phase_inc = '0;
    logic [ACC_W-1:0]        fm_word = '0;
    logic                    dith_en = 1'b0;
    logic signed [OUT_W-1:0] sin_o, cos_o;
    logic                    out_valid;

    int checks = 0;
    int fails  = 0;
    int dith_moved = 0;

    int    exp_idx_q[$];
    bit    exp_dith_q[$];
    string exp_tag_q[$];

    logic [ACC_W-1:0] m_acc;
    int               m_ph;
    bit               m_ph_dith;
    bit               m_phv;

    always #4 clk = ~clk;

    nco_octant_osc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .phase_inc (phase_inc),
        .fm_word   (fm_word),
        .dith_en   (dith_en),
        .sin_o     (sin_o),
        .cos_o     (cos_o),
        .out_valid (out_valid)
    );

    function automatic int ev(input int idx, input bit want_cos);
        real th, v;
        th = 2.0 * 3.14159265358979323846 * (real'(idx) + 0.5) / real'(NIDX);
        v  = AMPR * (want_cos ? $cos(th) : $sin(th));
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        clk_en = 1'b0;
        repeat (3) @(negedge clk);
        m_acc = '0;
        m_phv = 1'b0;
        rst_n = 1'b1;
    endtask

    // driver: applies enabled cycles and predicts the samples they produce
    task automatic run(input int n, input logic [ACC_W-1:0] inc,
                       input logic [ACC_W-1:0] fm, input bit dith, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            clk_en    = 1'b1;
            phase_inc = inc;
            fm_word   = fm;
            dith_en   = dith;
            if (m_phv) begin
                exp_idx_q.push_back(m_ph);
                exp_dith_q.push_back(m_ph_dith);
                exp_tag_q.push_back(tag);
            end
            m_ph      = int'(m_acc >> (ACC_W - PH_W));
            m_ph_dith = dith;
            m_phv     = 1'b1;
            m_acc     = m_acc + inc + fm;
        end
        @(negedge clk);
        clk_en = 1'b0;
    endtask

    // monitor: pops one prediction per valid sample
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && out_valid) begin
                if (exp_idx_q.size() == 0) begin
                    check(1'b0, "R6 unexpected sample", 1, 0);
                end else begin
                    int    idx;
                    bit    dth;
                    string tag;
                    bit    ok;
                    int    hit;
                    idx = exp_idx_q.pop_front();
                    dth = exp_dith_q.pop_front();
                    tag = exp_tag_q.pop_front();
                    ok  = 1'b0;
                    hit = 0;
                    if (dth) begin
                        for (int d = -1; d <= 1; d++) begin
                            int k;
                            k = (idx + d + NIDX) % NIDX;
                            if (!ok && int'(sin_o) == ev(k, 1'b0) && int'(cos_o) == ev(k, 1'b1)) begin
                                ok  = 1'b1;
                                hit = d;
                            end
                        end
                        if (ok && hit != 0) dith_moved++;
                        check(ok, {tag, " dithered sin"}, int'(sin_o), ev(idx, 1'b0));
                    end else begin
                        check(int'(sin_o) == ev(idx, 1'b0), {tag, " sin"}, int'(sin_o), ev(idx, 1'b0));
                        check(int'(cos_o) == ev(idx, 1'b1), {tag, " cos"}, int'(cos_o), ev(idx, 1'b1));
                    end
                end
            end
        end
    end

    initial begin
        #(8.0 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic signed [OUT_W-1:0] hs, hc;
        m_acc = '0;
        m_phv = 1'b0;
        m_ph  = 0;
        m_ph_dith = 1'b0;
        #1;
        // R1: reset state
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(sin_o == 0, "R1 sin in reset", int'(sin_o), 0);
        check(cos_o == 0, "R1 cos in reset", int'(cos_o), 0);
        do_reset();
        @(negedge clk);
        check(out_valid == 1'b0 && sin_o == 0, "R1 idle after reset", int'(out_valid), 0);

        // R6: latency of the first valid sample
        run(1, 16'h0100, 16'h0000, 1'b0, "R6");
        check(out_valid == 1'b0, "R6 not valid after first enable", int'(out_valid), 0);
        run(1, 16'h0100, 16'h0000, 1'b0, "R6");
        check(out_valid == 1'b1, "R6 valid after second enable", int'(out_valid), 1);
        check(int'(sin_o) == ev(0, 1'b0), "R6 first sample phase zero", int'(sin_o), ev(0, 1'b0));

        // R3 / R2: sweep every sector with a coarse step
        run(260, 16'h0100, 16'h0000, 1'b0, "R3");
        // R2: irregular step
        run(300, 16'h1234, 16'h0000, 1'b0, "R2");

        // R5: idle hold with a changing increment
        hs = sin_o;
        hc = cos_o;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            phase_inc = 16'h7777 + 16'(i);
            check(out_valid == 1'b0, "R5 valid low while idle", int'(out_valid), 0);
            check(sin_o == hs && cos_o == hc, "R5 outputs held", int'(sin_o), int'(hs));
        end
        run(40, 16'h0400, 16'h0000, 1'b0, "R5 resume");

        // R4: signed modulation word, negative and positive
        run(120, 16'h0200, 16'hFF80, 1'b0, "R4 negative fm");
        run(120, 16'h0200, 16'h0123, 1'b0, "R4 positive fm");

        // R10: minimum frequency step
        do_reset();
        run(200, 16'h0001, 16'h0000, 1'b0, "R10");

        // R7: dither with phase pinned at zero
        do_reset();
        run(200, 16'h0000, 16'h0000, 1'b1, "R7");
        repeat (4) @(negedge clk);
        check(dith_moved > 0, "R7 dither moved the index", dith_moved, 1);
        // R7: dither off again gives exact values
        run(60, 16'h0333, 16'h0000, 1'b0, "R7 off");

        repeat (4) @(negedge clk);
        check(exp_idx_q.size() == 0, "R6 all predicted samples seen", exp_idx_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule